// File: doc/BRIEF.md
# Three-Wire Serial Write Router

This block sits between an external host's three-wire serial write port (an active-low load strobe, a data line and a bit clock) and a group of downstream serial slaves that share one data wire and one clock wire. Each slave has its own active-low load line. The host puts a three-bit target code at the head of every write. The block collects that code, decodes it, and from then on passes the remaining bits through to the chosen slave as they arrive. The block does not store the payload and does not check it.

All three host pins are asynchronous to the system clock and pass through a synchronizer first. A write begins when the host load strobe goes low. Host bits are taken on each rising edge of the host clock. A write ends when the strobe returns high, and that releases every slave load line.

Target code 000 is the block's own local space. Writes with that code never reach a slave. Instead, the bits of such a write are shifted into a local word that sits on an output.

Top module: `serial_steer`

## Requirements
- R1: After reset, every slave load line is high, the forwarded clock and data are low, and the local word is zero.
- R2: The first three host bits of a write form the target code, most significant bit first. A code k from 1 to 7 drives load line bit k-1 low for the rest of the write.
- R3: At most one slave load line is low at any time.
- R4: While the target code is being collected, no load line is low and the forwarded clock stays low.
- R5: Every host bit after the target code is forwarded in order and unchanged, with one forwarded rising clock edge per host rising edge. This starts with the read/write flag and includes a flag of 1, since nothing is checked.
- R6: A write with code 000 lowers no load line and makes no forwarded clock edge. The local word is cleared at the start of each such write. Every following bit shifts in at bit 0, with older bits moving toward the most significant end. Writes to other codes leave the local word unchanged.
- R7: Within three system clock cycles after the host strobe rises, all load lines are high again.
- R8: If the strobe rises before all three code bits have arrived, no load line is lowered, no clock edge is forwarded, and the next write is routed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_ld_n | input | 1 | Host load strobe, active low, asynchronous |
| host_dat | input | 1 | Host serial data, asynchronous |
| host_sck | input | 1 | Host bit clock, asynchronous |
| tgt_ld_n | output | 7 | Slave load lines, active low; bit k-1 serves code k |
| fwd_sck | output | 1 | Forwarded clock shared by all slaves |
| fwd_dat | output | 1 | Forwarded data shared by all slaves |
| local_word | output | 16 | Bits of the latest code-000 write |

## Verification
Writes are sent to every external code, from 001 to 111, with payloads of different lengths and patterns. This shows that each code lowers only its own line and that the forwarded bit count and order follow the payload. One write carries a read/write flag of 1, to show that the bits are passed on without inspection. Two code-000 writes of different lengths show the local word being cleared and refilled, and the external writes in between show that they leave it alone. Strobe releases after zero and after two code bits separate a discarded partial code from a real selection.

// File: rtl/steer_pkg.sv
package steer_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SEL  = 2'd1,
        PH_FWD  = 2'd2
    } phase_t;

    typedef struct packed {
        logic ld_n;
        logic dat;
        logic sck;
    } host_pins_t;

    function automatic logic rose(input logic now, input logic prev);
        return now & ~prev;
    endfunction
endpackage

// File: rtl/steer_sync.sv
module steer_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/steer_fsm.sv
module steer_fsm
    import steer_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_s,
    input  logic             dat_s,
    input  logic             sck_rise,
    output phase_t           phase,
    output logic [SEL_W-1:0] code,
    output logic             fwd_rise
);
    localparam int CNT_W = $clog2(SEL_W + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            code  <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (!ld_s) begin
                        phase <= PH_SEL;
                        cnt   <= '0;
                    end
                end
                PH_SEL: begin
                    if (ld_s) begin
                        phase <= PH_IDLE;
                    end else if (sck_rise) begin
                        code <= {code[SEL_W-2:0], dat_s};
                        if (cnt == CNT_W'(SEL_W - 1)) phase <= PH_FWD;
                        else cnt <= cnt + 1'b1;
                    end
                end
                PH_FWD: begin
                    if (ld_s) phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign fwd_rise = sck_rise && (phase == PH_FWD);

    // R2: the code phase never counts past its field width
    assert_sel_count_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SEL) |-> (cnt < CNT_W'(SEL_W)));

    // R7: a high strobe always returns the sequencer to idle
    assert_strobe_idle_R7: assert property (@(posedge clk) disable iff (rst)
        ld_s |=> (phase == PH_IDLE));
endmodule

// File: rtl/steer_route.sv
module steer_route
    import steer_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int LOCAL_W = 16,
    localparam int N_EXT = (1 << SEL_W) - 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ld_s,
    input  phase_t             phase,
    input  logic [SEL_W-1:0]   code,
    input  logic               fwd_rise,
    input  logic               sck_s,
    input  logic               dat_s,
    output logic [N_EXT-1:0]   tgt_ld_n,
    output logic               out_sck,
    output logic               out_dat,
    output logic [LOCAL_W-1:0] local_word
);
    logic   ext_sel;
    logic   armed;
    logic   entry;
    phase_t phase_d;

    assign ext_sel = (phase == PH_FWD) && (code != '0);
    assign entry   = (phase == PH_FWD) && (phase_d != PH_FWD);

    for (genvar g = 0; g < N_EXT; g++) begin : g_ld
        assign tgt_ld_n[g] = !(ext_sel && (code == SEL_W'(g + 1)));
    end

    always_ff @(posedge clk) begin
        if (rst) phase_d <= PH_IDLE;
        else     phase_d <= phase;
    end

    // Forwarded clock is enabled only after host clock is seen low in
    // the forwarding phase, so the last code edge is never replayed.
    always_ff @(posedge clk) begin
        if (rst || phase != PH_FWD) armed <= 1'b0;
        else if (!sck_s)            armed <= 1'b1;
    end

    assign out_sck = ext_sel & armed & sck_s;
    assign out_dat = ext_sel & dat_s;

    always_ff @(posedge clk) begin
        if (rst)                                local_word <= '0;
        else if (entry && code == '0)           local_word <= '0;
        else if (fwd_rise && code == '0)        local_word <= {local_word[LOCAL_W-2:0], dat_s};
    end

    // R3: never more than one slave selected
    assert_one_load_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~tgt_ld_n));

    // R4: no forwarded clock while no slave is selected
    assert_clk_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (&tgt_ld_n) |-> !out_sck);

    // R7: strobe high is followed by all load lines released
    assert_release_R7: assert property (@(posedge clk) disable iff (rst)
        ld_s |=> (&tgt_ld_n));

    // R6: the local word moves only on a local bit or a local frame start
    assert_local_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!fwd_rise && !entry) |=> $stable(local_word));
endmodule

// File: rtl/serial_steer.sv
module serial_steer
    import steer_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int LOCAL_W = 16,
    parameter int SYNC_STAGES = 2,
    localparam int N_EXT = (1 << SEL_W) - 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_ld_n,
    input  logic               host_dat,
    input  logic               host_sck,
    output logic [N_EXT-1:0]   tgt_ld_n,
    output logic               fwd_sck,
    output logic               fwd_dat,
    output logic [LOCAL_W-1:0] local_word
);
    localparam int PW = $bits(host_pins_t);
    localparam host_pins_t PIN_IDLE = '{ld_n: 1'b1, dat: 1'b0, sck: 1'b0};

    host_pins_t raw, syn;
    logic       sck_d;
    logic       sck_rise;
    logic       fwd_rise;
    phase_t     phase;
    logic [SEL_W-1:0] code;

    assign raw = '{ld_n: host_ld_n, dat: host_dat, sck: host_sck};

    steer_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (syn)
    );

    always_ff @(posedge clk) begin
        if (rst) sck_d <= 1'b0;
        else     sck_d <= syn.sck;
    end

    assign sck_rise = rose(syn.sck, sck_d);

    steer_fsm #(.SEL_W(SEL_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ld_s     (syn.ld_n),
        .dat_s    (syn.dat),
        .sck_rise (sck_rise),
        .phase    (phase),
        .code     (code),
        .fwd_rise (fwd_rise)
    );

    steer_route #(.SEL_W(SEL_W), .LOCAL_W(LOCAL_W)) u_route (
        .clk        (clk),
        .rst        (rst),
        .ld_s       (syn.ld_n),
        .phase      (phase),
        .code       (code),
        .fwd_rise   (fwd_rise),
        .sck_s      (syn.sck),
        .dat_s      (syn.dat),
        .tgt_ld_n   (tgt_ld_n),
        .out_sck    (fwd_sck),
        .out_dat    (fwd_dat),
        .local_word (local_word)
    );
endmodule

// File: tb/sim_serial_steer.sv
module sim_serial_steer;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;
    // {code[24:22], rw[21], nbits[20:16], payload[15:0]}
    localparam logic [24:0] VEC [NV] = '{
        {3'd1, 1'b0, 5'd8,  16'h00A5},
        {3'd2, 1'b0, 5'd12, 16'h03C7},
        {3'd3, 1'b0, 5'd16, 16'hBEEF},
        {3'd0, 1'b0, 5'd16, 16'h1234},
        {3'd4, 1'b0, 5'd7,  16'h0055},
        {3'd5, 1'b0, 5'd4,  16'h0009},
        {3'd6, 1'b0, 5'd10, 16'h02AB},
        {3'd7, 1'b1, 5'd5,  16'h0013},
        {3'd0, 1'b0, 5'd6,  16'h002D}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_ld_n = 1'b1;
    logic        host_dat = 1'b0;
    logic        host_sck = 1'b0;
    logic [6:0]  tgt_ld_n;
    logic        fwd_sck;
    logic        fwd_dat;
    logic [15:0] local_word;

    int checks = 0;
    int errors = 0;

    logic        mon_en = 1'b0;
    logic        in_sel = 1'b0;
    logic [6:0]  seen_low = '0;
    logic [6:0]  sel_low = '0;
    logic        sel_sck = 1'b0;
    int          fwd_cnt = 0;
    logic [31:0] fwd_bits = '0;
    logic [15:0] exp_local = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_steer u0 (
        .clk        (clk),
        .rst        (rst),
        .host_ld_n  (host_ld_n),
        .host_dat   (host_dat),
        .host_sck   (host_sck),
        .tgt_ld_n   (tgt_ld_n),
        .fwd_sck    (fwd_sck),
        .fwd_dat    (fwd_dat),
        .local_word (local_word)
    );

    always @(negedge clk) begin
        if (mon_en) begin
            seen_low = seen_low | ~tgt_ld_n;
            if (in_sel) begin
                sel_low = sel_low | ~tgt_ld_n;
                if (fwd_sck) sel_sck = 1'b1;
            end
        end
    end

    always @(posedge fwd_sck) begin
        if (mon_en) begin
            fwd_cnt  = fwd_cnt + 1;
            fwd_bits = {fwd_bits[30:0], fwd_dat};
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_frame(input logic [2:0] code, input logic rw,
                             input int nbits, input logic [15:0] payload,
                             input int limit_in);
        int total;
        int limit;
        logic full;
        logic b;
        logic [31:0] exp_bits;
        logic [6:0] exp_mask;
        int exp_cnt;
        string rq;
        total = 4 + nbits;
        limit = (limit_in < 0) ? total : limit_in;
        full = (limit == total);
        rq = full ? "R2" : "R8";
        exp_bits = '0;
        seen_low = '0; sel_low = '0; sel_sck = 1'b0;
        fwd_cnt = 0; fwd_bits = '0;
        @(negedge clk);
        mon_en = 1'b1; in_sel = 1'b1;
        host_ld_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < limit; i++) begin
            if (i < 3) b = code[2-i];
            else if (i == 3) b = rw;
            else b = payload[i-4];
            if (i >= 3) exp_bits = {exp_bits[30:0], b};
            host_dat = b;
            repeat (4) @(negedge clk);
            host_sck = 1'b1;
            if (i == 2) in_sel = 1'b0;
            repeat (4) @(negedge clk);
            host_sck = 1'b0;
        end
        in_sel = 1'b0;
        repeat (4) @(negedge clk);
        host_ld_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7", "load lines after strobe release", {25'd0, tgt_ld_n}, 32'h7F);
        repeat (6) @(negedge clk);
        mon_en = 1'b0;

        exp_mask = (full && code != 3'd0) ? 7'(1 << (code - 3'd1)) : 7'd0;
        exp_cnt  = (full && code != 3'd0) ? nbits + 1 : 0;
        if (full && code == 3'd0) exp_local = exp_bits[15:0];

        chk(rq, "load lines lowered", {25'd0, seen_low}, {25'd0, exp_mask});
        chk("R3", "single load low", $countones(seen_low) <= 1, 32'd1);
        chk("R4", "load low during code", {25'd0, sel_low}, 32'd0);
        chk("R4", "clock during code", {31'd0, sel_sck}, 32'd0);
        chk(code == 3'd0 ? "R6" : (full ? "R5" : "R8"), "forwarded edges", fwd_cnt, exp_cnt);
        if (exp_cnt > 0)
            chk("R5", "forwarded bits", fwd_bits, exp_bits);
        chk("R6", "local word", {16'd0, local_word}, {16'd0, exp_local});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "load lines at reset", {25'd0, tgt_ld_n}, 32'h7F);
        chk("R1", "fwd clock at reset", {31'd0, fwd_sck}, 32'd0);
        chk("R1", "fwd data at reset", {31'd0, fwd_dat}, 32'd0);
        chk("R1", "local word at reset", {16'd0, local_word}, 32'd0);

        for (int v = 0; v < NV; v++)
            run_frame(VEC[v][24:22], VEC[v][21], int'(VEC[v][20:16]), VEC[v][15:0], -1);

        // R8 partial codes are discarded
        run_frame(3'd3, 1'b0, 4, 16'h000F, 2);
        run_frame(3'd5, 1'b0, 4, 16'h000F, 0);
        // R8 next write after an abort routes normally
        run_frame(3'd3, 1'b0, 6, 16'h0015, -1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule